// File: doc/BRIEF.md
# Windowed 16-Point Doppler Power Engine

This block performs the slow-time Doppler step of moving-target indication for one range cell. A packet holds sixteen complex pulse returns from that cell. The block scales each return by its own taper coefficient, which is held in a parameter vector inside the block. It then runs a sixteen-point discrete Fourier transform as two radix-4 passes. Between the passes, the non-trivial rotation factors are applied with a multiplier and the trivial ones by swapping and negating components. Finally it streams out the energy of every Doppler channel, re²+im², in ascending channel order. No square root is taken.

Samples enter on a valid/ready stream of 16-bit signed I/Q pairs. Results leave on a second valid/ready stream that carries the channel number with each power word. A controller with four states sequences the work, and a single working store of sixteen complex words is reused in place.

- `ST_LOAD` tapers each arriving sample and writes it to a digit-reversed slot. The sixteenth acceptance moves to `ST_XFORM1`.
- `ST_XFORM1` runs one first-pass butterfly per cycle, followed by the rotation. After four groups it moves to `ST_XFORM2`.
- `ST_XFORM2` gathers stride-four groups and runs the second pass. After four groups it moves to `ST_EMIT`.
- `ST_EMIT` hands out channels 0 to 15. The handshake on channel 15 returns the controller to `ST_LOAD`.
- Reset from any state returns the controller to `ST_LOAD`.

Top module: `doppler16_engine`

## Requirements
- R1: While reset is asserted and on the first cycle after it, in_ready is 1 and out_valid is 0. A reset in the middle of a packet discards the partial packet, so the next sixteen accepted samples form a complete new packet.
- R2: A packet is exactly sixteen accepted samples, where an accepted sample is in_valid and in_ready both high at a clock edge. After the sixteenth, in_ready stays 0 until the edge that hands off channel 15. It is 1 from the next cycle on.
- R3: Sample n, counted 0 to 15 in arrival order, is multiplied by coefficient n, taken from WIN_COEF bits [16n+15:16n]. Coefficients are unsigned Q1.15, so 0x8000 is 1.0 and 0xFFFF is just under 2.0. The product is rounded to nearest, and a coefficient of 0 gives exactly zero power in every channel.
- R4: The power of channel k equals |Σ w_n·x_n·e^(−j2πkn/16)|², where w_n is the coefficient as a real number. The result is accurate to within 12 LSB of error on the magnitude.
- R5: Each packet yields exactly sixteen output beats, and out_chan runs 0, 1, …, 15 in that order.
- R6: While out_valid is 1 and out_ready is 0, out_valid, out_chan and out_power hold their values.
- R7: Full-scale input (I = 32767, Q = −32768 in every pulse) gives correct channel powers with no wrap or saturation.
- R8: in_valid and the input data are ignored while in_ready is 0. Samples offered during computation do not change the next packet's results.
- R9: out_valid becomes 1 on the eighth rising edge after the edge that accepts the sixteenth sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take a sample |
| in_re | input | IW (16) | In-phase sample, signed |
| in_im | input | IW (16) | Quadrature sample, signed |
| out_valid | output | 1 | Channel power available |
| out_ready | input | 1 | Downstream takes the power word |
| out_chan | output | 4 | Doppler channel index of out_power |
| out_power | output | 2·(IW+6) (44) | Unsigned re²+im² of the channel |

## Verification
Any fault in the working store, the slot ordering or the rotation selection surfaces in the very first packet as channel powers that are far off the reference transform. A mis-slotted sample moves energy into wrong channels, and a wrong rotation smears a pure tone across several bins. Controller faults show up within one packet as a wrong latency count, a skipped or repeated channel number, or in_ready rising too early. Impulses at tapered, maximal and zero-weight positions, tones, full-scale and pseudo-random packets separate windowing, ordering and overflow faults from one another.

// File: rtl/doppler16_pkg.sv
package doppler16_pkg;
    localparam int NPT    = 16;
    localparam int RADIX  = 4;
    localparam int CNT_W  = $clog2(NPT);
    localparam int GRP_W  = $clog2(RADIX);
    localparam int TWID_W = 16;

    typedef enum logic [1:0] {
        ST_LOAD,
        ST_XFORM1,
        ST_XFORM2,
        ST_EMIT
    } dop_state_e;

    // arrival index n = 4*hi + lo is stored at slot 4*lo + hi
    function automatic logic [CNT_W-1:0] digit_rev(input logic [CNT_W-1:0] n);
        return {n[GRP_W-1:0], n[CNT_W-1:GRP_W]};
    endfunction
endpackage

// File: rtl/dop_window_mul.sv
module dop_window_mul #(
    parameter int IW = 16,
    parameter int CW = 16,
    parameter int BW = 22
) (
    input  logic signed [IW-1:0] x_re,
    input  logic signed [IW-1:0] x_im,
    input  logic        [CW-1:0] coef,
    output logic signed [BW-1:0] y_re,
    output logic signed [BW-1:0] y_im
);
    localparam int PRW = IW + CW + 1;
    localparam int RND = 1 << (CW - 2);

    logic signed [PRW-1:0] coef_s;
    logic signed [PRW-1:0] prod_re;
    logic signed [PRW-1:0] prod_im;

    always_comb begin
        coef_s  = PRW'($signed({1'b0, coef}));
        prod_re = PRW'(x_re) * coef_s + PRW'(RND);
        prod_im = PRW'(x_im) * coef_s + PRW'(RND);
        y_re    = BW'(prod_re >>> (CW - 1));
        y_im    = BW'(prod_im >>> (CW - 1));
    end
endmodule

// File: rtl/dop_radix4.sv
module dop_radix4 #(
    parameter int BW = 22
) (
    input  logic signed [BW-1:0] a_re [4],
    input  logic signed [BW-1:0] a_im [4],
    output logic signed [BW-1:0] z_re [4],
    output logic signed [BW-1:0] z_im [4]
);
    // -j and +j terms are realised as component swaps with one negation
    always_comb begin
        z_re[0] = a_re[0] + a_re[1] + a_re[2] + a_re[3];
        z_im[0] = a_im[0] + a_im[1] + a_im[2] + a_im[3];
        z_re[1] = a_re[0] + a_im[1] - a_re[2] - a_im[3];
        z_im[1] = a_im[0] - a_re[1] - a_im[2] + a_re[3];
        z_re[2] = a_re[0] - a_re[1] + a_re[2] - a_re[3];
        z_im[2] = a_im[0] - a_im[1] + a_im[2] - a_im[3];
        z_re[3] = a_re[0] - a_im[1] - a_re[2] + a_im[3];
        z_im[3] = a_im[0] + a_re[1] - a_im[2] - a_re[3];
    end
endmodule

// File: rtl/dop_twiddle.sv
module dop_twiddle
    import doppler16_pkg::*;
#(
    parameter int BW = 22
) (
    input  logic        [CNT_W-1:0] m,
    input  logic signed [BW-1:0]    x_re,
    input  logic signed [BW-1:0]    x_im,
    output logic signed [BW-1:0]    y_re,
    output logic signed [BW-1:0]    y_im
);
    localparam int PW  = BW + TWID_W + 1;
    localparam int RND = 1 << (TWID_W - 2);

    logic signed [TWID_W-1:0] c_re;
    logic signed [TWID_W-1:0] c_im;
    logic signed [PW-1:0]     p_re;
    logic signed [PW-1:0]     p_im;

    // rotation e^(-j*2*pi*m/16) in signed Q1.15
    always_comb begin
        unique case (m)
            4'd0:    begin c_re =  16'sd32767; c_im =  16'sd0;     end
            4'd1:    begin c_re =  16'sd30274; c_im = -16'sd12540; end
            4'd2:    begin c_re =  16'sd23170; c_im = -16'sd23170; end
            4'd3:    begin c_re =  16'sd12540; c_im = -16'sd30274; end
            4'd4:    begin c_re =  16'sd0;     c_im = -16'sd32767; end
            4'd5:    begin c_re = -16'sd12540; c_im = -16'sd30274; end
            4'd6:    begin c_re = -16'sd23170; c_im = -16'sd23170; end
            4'd7:    begin c_re = -16'sd30274; c_im = -16'sd12540; end
            4'd8:    begin c_re = -16'sd32767; c_im =  16'sd0;     end
            4'd9:    begin c_re = -16'sd30274; c_im =  16'sd12540; end
            4'd10:   begin c_re = -16'sd23170; c_im =  16'sd23170; end
            4'd11:   begin c_re = -16'sd12540; c_im =  16'sd30274; end
            4'd12:   begin c_re =  16'sd0;     c_im =  16'sd32767; end
            4'd13:   begin c_re =  16'sd12540; c_im =  16'sd30274; end
            4'd14:   begin c_re =  16'sd23170; c_im =  16'sd23170; end
            default: begin c_re =  16'sd30274; c_im =  16'sd12540; end
        endcase
    end

    always_comb begin
        p_re = PW'(x_re) * PW'(c_re) - PW'(x_im) * PW'(c_im) + PW'(RND);
        p_im = PW'(x_re) * PW'(c_im) + PW'(x_im) * PW'(c_re) + PW'(RND);
        unique case (m)
            4'd0:    begin y_re =  x_re; y_im =  x_im; end
            4'd4:    begin y_re =  x_im; y_im = -x_re; end
            4'd8:    begin y_re = -x_re; y_im = -x_im; end
            4'd12:   begin y_re = -x_im; y_im =  x_re; end
            default: begin
                y_re = BW'(p_re >>> (TWID_W - 1));
                y_im = BW'(p_im >>> (TWID_W - 1));
            end
        endcase
    end
endmodule

// File: rtl/dop_power.sv
module dop_power #(
    parameter int BW = 22,
    parameter int PW = 44
) (
    input  logic signed [BW-1:0] v_re,
    input  logic signed [BW-1:0] v_im,
    output logic        [PW-1:0] pwr
);
    logic signed [PW-1:0] sq_re;
    logic signed [PW-1:0] sq_im;

    always_comb begin
        sq_re = PW'(v_re) * PW'(v_re);
        sq_im = PW'(v_im) * PW'(v_im);
        pwr   = $unsigned(sq_re) + $unsigned(sq_im);
    end
endmodule

// File: rtl/doppler16_engine.sv
module doppler16_engine
    import doppler16_pkg::*;
#(
    parameter int IW = 16,
    parameter int CW = 16,
    parameter logic [NPT*CW-1:0] WIN_COEF = {NPT{1'b1, {(CW-1){1'b0}}}},
    localparam int BW = IW + 6,
    localparam int PW = 2 * BW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic signed [IW-1:0] in_re,
    input  logic signed [IW-1:0] in_im,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [CNT_W-1:0]     out_chan,
    output logic [PW-1:0]        out_power
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NPT - 1);
    localparam logic [GRP_W-1:0] LAST_GRP = GRP_W'(RADIX - 1);

    dop_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [GRP_W-1:0]  grp;

    logic signed [BW-1:0] mem_re [NPT];
    logic signed [BW-1:0] mem_im [NPT];

    logic [CW-1:0]        coef;
    logic signed [BW-1:0] win_re, win_im;
    logic signed [BW-1:0] bf_in_re [RADIX];
    logic signed [BW-1:0] bf_in_im [RADIX];
    logic signed [BW-1:0] bf_re    [RADIX];
    logic signed [BW-1:0] bf_im    [RADIX];
    logic signed [BW-1:0] tw_re    [RADIX];
    logic signed [BW-1:0] tw_im    [RADIX];
    logic [PW-1:0]        pwr;

    assign grp  = cnt_q[GRP_W-1:0];
    assign coef = WIN_COEF[cnt_q*CW +: CW];

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_LOAD: begin
                if (in_valid) begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == LAST_IDX) state_d = ST_XFORM1;
                end
            end
            ST_XFORM1: begin
                if (grp == LAST_GRP) begin
                    state_d = ST_XFORM2;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_XFORM2: begin
                if (grp == LAST_GRP) begin
                    state_d = ST_EMIT;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_EMIT: begin
                if (out_ready) begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == LAST_IDX) state_d = ST_LOAD;
                end
            end
            default: begin
                state_d = ST_LOAD;
                cnt_d   = '0;
            end
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        in_ready  = (state_q == ST_LOAD);
        out_valid = (state_q == ST_EMIT);
        out_chan  = cnt_q;
        out_power = pwr;
    end

    // ---------------- datapath ----------------
    dop_window_mul #(.IW(IW), .CW(CW), .BW(BW)) u_win (
        .x_re (in_re),
        .x_im (in_im),
        .coef (coef),
        .y_re (win_re),
        .y_im (win_im)
    );

    // pass 1 reads a contiguous group, pass 2 gathers with stride RADIX
    always_comb begin
        for (int i = 0; i < RADIX; i++) begin
            if (state_q == ST_XFORM2) begin
                bf_in_re[i] = mem_re[{GRP_W'(i), grp}];
                bf_in_im[i] = mem_im[{GRP_W'(i), grp}];
            end else begin
                bf_in_re[i] = mem_re[{grp, GRP_W'(i)}];
                bf_in_im[i] = mem_im[{grp, GRP_W'(i)}];
            end
        end
    end

    dop_radix4 #(.BW(BW)) u_bfly (
        .a_re (bf_in_re),
        .a_im (bf_in_im),
        .z_re (bf_re),
        .z_im (bf_im)
    );

    generate
        for (genvar k = 0; k < RADIX; k++) begin : g_rot
            logic [CNT_W-1:0] rot_idx;
            assign rot_idx = CNT_W'(grp * k);
            dop_twiddle #(.BW(BW)) u_tw (
                .m    (rot_idx),
                .x_re (bf_re[k]),
                .x_im (bf_im[k]),
                .y_re (tw_re[k]),
                .y_im (tw_im[k])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        unique case (state_q)
            ST_LOAD: begin
                if (in_valid) begin
                    mem_re[digit_rev(cnt_q)] <= win_re;
                    mem_im[digit_rev(cnt_q)] <= win_im;
                end
            end
            ST_XFORM1: begin
                for (int k = 0; k < RADIX; k++) begin
                    mem_re[{grp, GRP_W'(k)}] <= tw_re[k];
                    mem_im[{grp, GRP_W'(k)}] <= tw_im[k];
                end
            end
            ST_XFORM2: begin
                for (int k = 0; k < RADIX; k++) begin
                    mem_re[{GRP_W'(k), grp}] <= bf_re[k];
                    mem_im[{GRP_W'(k), grp}] <= bf_im[k];
                end
            end
            default: ;
        endcase
    end

    dop_power #(.BW(BW), .PW(PW)) u_pwr (
        .v_re (mem_re[cnt_q]),
        .v_im (mem_im[cnt_q]),
        .pwr  (pwr)
    );

    // ---------------- assertions ----------------
    a_r6_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_chan) && $stable(out_power)));

    a_r5_first_channel: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_chan == '0));

    a_r5_channel_step: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_chan != LAST_IDX)
        |=> (out_valid && out_chan == $past(out_chan) + 1'b1));

    a_r2_reopen_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_chan == LAST_IDX) |=> (in_ready && !out_valid));

    a_r2_stay_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !(out_valid && out_ready && out_chan == LAST_IDX)) |=> !in_ready);
endmodule

// File: tb/doppler16_engine_bench.sv
`timescale 1ns/1ps
module doppler16_engine_bench;
    localparam int PWW = 44;
    localparam logic [255:0] WPACK = {
        16'h0000, 16'h1800, 16'h3000, 16'h4C00, 16'h6400, 16'h7400, 16'h7E00, 16'h8000,
        16'hFFFF, 16'h7E00, 16'h7400, 16'h6400, 16'h4C00, 16'h3000, 16'h1800, 16'h0800};
    // kind: 0 impulse at n=par, 1 tone at channel par, 2 full-scale constant, 3 pseudo-random
    // last field: requirement number the row targets
    localparam int NV = 7;
    localparam int VEC [NV][4] = '{
        '{0,  1000,  0, 4},   // R4 impulse at first pulse
        '{1,  8000,  3, 4},   // R4 tone, also R6 stall
        '{1, 12000, 11, 4},   // R4 tone, also R8 garbage offered
        '{3,     0,  0, 4},   // R4 pseudo-random
        '{0, 10000,  7, 3},   // R3 impulse on 0xFFFF weight
        '{0, 20000, 15, 3},   // R3 impulse on zero weight
        '{2, 32767,  0, 7}    // R7 full scale
    };

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst_n;
    logic              in_valid;
    logic              in_ready;
    logic signed [15:0] in_re, in_im;
    logic              out_valid;
    logic              out_ready;
    logic [3:0]        out_chan;
    logic [PWW-1:0]    out_power;

    int n_tests = 0;
    int n_fail  = 0;
    int sr [16];
    int si [16];

    doppler16_engine #(.WIN_COEF(WPACK)) u_doppler16_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_re     (in_re),
        .in_im     (in_im),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_chan  (out_chan),
        .out_power (out_power)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input real act, input real exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0.2f expected %0.2f", req, what, act, exp);
        end
    endtask

    function automatic real win_val(input int n);
        return real'(WPACK[16*n +: 16]) / 32768.0;
    endfunction

    function automatic real ref_pow(input int k);
        real xr = 0.0, xi = 0.0;
        for (int n = 0; n < 16; n++) begin
            real th = -2.0 * 3.14159265358979 * real'(k * n) / 16.0;
            real ar = real'(sr[n]) * win_val(n);
            real ai = real'(si[n]) * win_val(n);
            xr += ar * $cos(th) - ai * $sin(th);
            xi += ar * $sin(th) + ai * $cos(th);
        end
        return xr * xr + xi * xi;
    endfunction

    task automatic make_packet(input int kind, input int amp, input int par);
        for (int n = 0; n < 16; n++) begin
            real th = 2.0 * 3.14159265358979 * real'(par * n) / 16.0;
            case (kind)
                0: begin sr[n] = (n == par) ? amp : 0; si[n] = (n == par) ? -amp / 2 : 0; end
                1: begin sr[n] = int'(real'(amp) * $cos(th)); si[n] = int'(real'(amp) * $sin(th)); end
                2: begin sr[n] = amp; si[n] = -amp - 1; end
                default: begin
                    sr[n] = ((n * 12345 + 678) % 65536) - 32768;
                    si[n] = ((n * 4321 + 99) % 65536) - 32768;
                end
            endcase
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_re = '0;
        in_im = '0;
        out_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", real'(in_ready), 1.0);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", real'(out_valid), 0.0);
    endtask

    task automatic run_packet(input string req, input bit stall, input bit garbage);
        int lat;
        logic [PWW-1:0] held;
        for (int n = 0; n < 16; n++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_re = 16'(sr[n]);
            in_im = 16'(si[n]);
            while (!in_ready) @(negedge clk);
            @(posedge clk);
        end
        lat = 0;
        forever begin
            @(negedge clk);
            lat++;
            if (out_valid || lat > 40) break;
            if (garbage) begin
                chk(in_ready == 1'b0, "R8", "in_ready while busy", real'(in_ready), 0.0);
                in_valid = 1'b1;
                in_re = 16'(lat * 7777);
                in_im = 16'(lat * -3131);
            end else begin
                in_valid = 1'b0;
            end
        end
        in_valid = 1'b0;
        // R9: edge E8 after the 16th acceptance edge is seen at the 9th falling edge
        chk(lat == 9, "R9", "output latency", real'(lat), 9.0);
        for (int k = 0; k < 16; k++) begin
            real am, em;
            chk(out_valid == 1'b1, "R5", "out_valid during burst", real'(out_valid), 1.0);
            chk(out_chan == 4'(k), "R5", "channel order", real'(out_chan), real'(k));
            chk(in_ready == 1'b0, "R2", "in_ready during output", real'(in_ready), 0.0);
            am = $sqrt(real'(out_power));
            em = $sqrt(ref_pow(k));
            chk(((am - em) <= 12.0) && ((em - am) <= 12.0), req,
                $sformatf("channel %0d power", k), real'(out_power), ref_pow(k));
            if (stall && k == 5) begin
                out_ready = 1'b0;
                held = out_power;
                for (int s = 0; s < 3; s++) begin
                    @(negedge clk);
                    chk(out_valid && out_power == held && out_chan == 4'd5, "R6",
                        "output held under stall", real'(out_power), real'(held));
                end
                out_ready = 1'b1;
            end
            @(posedge clk);
            @(negedge clk);
        end
        chk(in_ready == 1'b1, "R2", "in_ready after last channel", real'(in_ready), 1.0);
        chk(out_valid == 1'b0, "R5", "no 17th beat", real'(out_valid), 0.0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        for (int v = 0; v < NV; v++) begin
            make_packet(VEC[v][0], VEC[v][1], VEC[v][2]);
            run_packet($sformatf("R%0d", VEC[v][3]), v == 1, v == 2);
        end
        // R1: reset after five samples, then a fresh packet must be complete and correct
        for (int n = 0; n < 5; n++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_re = 16'(n * 901);
            in_im = 16'(n * 55);
            @(posedge clk);
        end
        do_reset();
        make_packet(0, 5000, 3);
        run_packet("R1", 1'b0, 1'b0);
        // R8: data offered during the previous computation must not leak into this one
        make_packet(1, 15000, 8);
        run_packet("R8", 1'b0, 1'b1);
        make_packet(1, 15000, 8);
        run_packet("R8", 1'b0, 1'b0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule